// File: doc/BRIEF.md
# Compare-Flag Interval Timer

An 8-bit timer/counter that counts on a pulse from its own prescaler and runs in one of two modes chosen by a mode input. In clear-on-compare mode the count climbs to a period register and returns to zero. In PWM mode the same period register sets the wrap point and also drives a single-edge waveform. Two compare channels, A and B, each watch the count and raise a sticky flag of their own. Neither channel ever changes the count.

Each compare flag appears a fixed number of clocks after the tick on which the match was seen. A match is therefore never lost, even when the channel value equals the period value and the counter has already gone back to zero. When software writes the counter, the compare on the next tick is suppressed, so a freshly written count does not produce a spurious flag. The overflow flag has a different meaning in each mode. Compare values are staged until the period boundary in PWM mode and take effect at once in clear-on-compare mode.

Top module: `cmp_timer`

## Requirements
- R1: In clear-on-compare mode (mode_pwm_i=0) each count tick moves the count from the period value to 0 and from any other value v to v+1 (mod 256). With period 2 and divide-by-1 the count reads 0,1,2,0,1,2.
- R2: Channels A and B never clear or load the counter. Each one sets only its own flag bit (flags_o[1] for A, flags_o[2] for B).
- R3: A match is taken on a count tick when the count equals the channel's active value. Its flag goes high on the third rising clock edge after the edge of that tick.
- R4: A channel whose value equals the period value still sets its flag once in every period.
- R5: In clear-on-compare mode the overflow flag flags_o[0] is set only when a tick moves the count from 255 to 0. Returning to 0 from a smaller period value leaves it untouched.
- R6: In PWM mode flags_o[0] is set on the tick that moves the count from the period value to 0.
- R7: In PWM mode a write to a compare register is held and becomes active on the tick that wraps the count at the period value. In clear-on-compare mode a write is active from the next clock.
- R8: A write to the counter blocks any match on the next count tick. Later ticks compare normally.
- R9: psc_sel_i selects the count tick: 0 gives no ticks, and 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 clocks. Matches and counting happen only on ticks.
- R10: A 1 on a bit of flag_clr_i clears that flag. When a set and a clear meet in the same cycle, the set wins.
- R11: pwm_o is high while mode_pwm_i=1 and the count is below the active channel-A value, and low otherwise. An active value of 0 keeps it low.
- R12: Register address 0 is the counter, 1 is compare A, 2 is compare B and 3 is the period. Reset gives count 0, compare values 0, period 255 and all flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_pwm_i | input | 1 | 1 selects PWM mode, 0 selects clear-on-compare mode |
| psc_sel_i | input | 3 | Prescaler select (stop, /1, /8, /64, /256, /1024) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 count, 1 compare A, 2 compare B, 3 period) |
| wr_data_i | input | 8 | Register write data |
| flag_clr_i | input | 3 | Write-1 flag clear {B, A, overflow} |
| flags_o | output | 3 | Sticky flags {B, A, overflow} |
| cnt_o | output | 8 | Current count |
| pwm_o | output | 1 | Waveform output |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a three-stage flag delay and a 10-bit prescaler. These widths keep a true 255-to-0 rollover and the /8 and /64 tick rates short enough to run many times. The three-stage delay lets a compare value equal to the period run its match through the pipeline after the counter has already cleared. A behavioural model, which keeps its delay line in queues, is checked against the count, the flags and the waveform on every clock. Directed checks cover counter-write blocking, the staging of compare values, set-over-clear priority and the overflow rules of each mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_CNT   = 2'd0,
    REG_CMP_A = 2'd1,
    REG_CMP_B = 2'd2,
    REG_TOP   = 2'd3
  } reg_sel_e;

  localparam int FLG_OVF = 0;
  localparam int NUM_CH  = 2;
  localparam int NUM_FLG = NUM_CH + 1;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask;
  logic             run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psc_q <= '0;
    else         psc_q <= psc_q + 1'b1;
  end

  always_comb begin
    run  = 1'b1;
    mask = '0;
    unique case (sel_i)
      3'd1:    mask = '0;
      3'd2:    mask = PSC_W'(7);
      3'd3:    mask = PSC_W'(63);
      3'd4:    mask = PSC_W'(255);
      3'd5:    mask = PSC_W'(1023);
      default: run  = 1'b0;
    endcase
  end

  assign tick_o = run && ((psc_q & mask) == mask);

  // R9
  div8_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd2 && $past(sel_i) == 3'd2 && tick_o) |-> !$past(tick_o));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         blk_o,
  output logic         wrap_o,
  output logic         roll_o
);
  logic [W-1:0] cnt_q;
  logic         blk_q;
  logic         at_top;

  assign at_top = (cnt_q == top_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (wr_i) begin
      cnt_q <= wr_data_i;
      blk_q <= 1'b1;
    end else if (tick_i) begin
      blk_q <= 1'b0;
      cnt_q <= at_top ? '0 : cnt_q + 1'b1;
    end
  end

  assign wrap_o = tick_i && !wr_i && at_top;
  assign roll_o = tick_i && !wr_i && (cnt_q == {W{1'b1}});
  assign cnt_o  = cnt_q;
  assign blk_o  = blk_q;

  // R1
  top_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && cnt_q == top_i) |=> (cnt_q == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int W        = 8,
  parameter int SYNC_DLY = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pwm_mode_i,
  input  logic         tick_i,
  input  logic         blk_i,
  input  logic [W-1:0] cnt_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         load_i,
  output logic [W-1:0] act_o,
  output logic         set_o
);
  logic [W-1:0]        stage_q;
  logic [W-1:0]        act_q;
  logic [SYNC_DLY-1:0] pipe_q;
  logic                match;

  assign match = tick_i && !blk_i && (cnt_i == act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      if (wr_i) stage_q <= wr_data_i;
      if (wr_i && !pwm_mode_i) act_q <= wr_data_i;
      else if (load_i)         act_q <= stage_q;
    end
  end

  generate
    if (SYNC_DLY > 1) begin : g_pipe
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[SYNC_DLY-2:0], match};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= match;
      end
    end
  endgenerate

  assign set_o = pipe_q[SYNC_DLY-1];
  assign act_o = act_q;

  // R7
  staged_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_mode_i && !load_i) |=> $stable(act_q));

  // R3
  first_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !blk_i && cnt_i == act_q) |=> pipe_q[0]);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int W        = 8,
  parameter int SYNC_DLY = 3,
  parameter int PSC_W    = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_pwm_i,
  input  logic [2:0]         psc_sel_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [W-1:0]       wr_data_i,
  input  logic [NUM_FLG-1:0] flag_clr_i,
  output logic [NUM_FLG-1:0] flags_o,
  output logic [W-1:0]       cnt_o,
  output logic               pwm_o
);
  logic               tick, blk, wrap, roll, ovf_evt;
  logic               wr_cnt, wr_top;
  logic [NUM_CH-1:0]  wr_cmp, cmp_set;
  logic [W-1:0]       top_q, cnt;
  logic [W-1:0]       cmp_act [NUM_CH];
  logic [NUM_FLG-1:0] flags_q;

  assign wr_cnt    = wr_en_i && (wr_addr_i == REG_CNT);
  assign wr_top    = wr_en_i && (wr_addr_i == REG_TOP);
  assign wr_cmp[0] = wr_en_i && (wr_addr_i == REG_CMP_A);
  assign wr_cmp[1] = wr_en_i && (wr_addr_i == REG_CMP_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     top_q <= '1;
    else if (wr_top) top_q <= wr_data_i;
  end

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (psc_sel_i),
    .tick_o(tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .wr_i     (wr_cnt),
    .wr_data_i(wr_data_i),
    .top_i    (top_q),
    .cnt_o    (cnt),
    .blk_o    (blk),
    .wrap_o   (wrap),
    .roll_o   (roll)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tmr_cmp_chan #(.W(W), .SYNC_DLY(SYNC_DLY)) u_ch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pwm_mode_i(mode_pwm_i),
        .tick_i    (tick),
        .blk_i     (blk),
        .cnt_i     (cnt),
        .wr_i      (wr_cmp[c]),
        .wr_data_i (wr_data_i),
        .load_i    (wrap && mode_pwm_i),
        .act_o     (cmp_act[c]),
        .set_o     (cmp_set[c])
      );
    end
  endgenerate

  // overflow meaning depends on mode
  assign ovf_evt = mode_pwm_i ? wrap : roll;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flag_clr_i) | {cmp_set, ovf_evt};
  end

  assign flags_o = flags_q;
  assign cnt_o   = cnt;
  assign pwm_o   = mode_pwm_i && (cnt < cmp_act[0]);

  // R10
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags_q & ~flag_clr_i)) |=>
      ((flags_q & $past(flags_q & ~flag_clr_i)) == $past(flags_q & ~flag_clr_i)));

  // R5
  ctc_no_top_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_pwm_i && tick && !wr_cnt && cnt == top_q && top_q != '1
     && !flags_q[FLG_OVF]) |=> !flags_q[FLG_OVF]);

  // R11
  pwm_start_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_pwm_i && cnt_o == '0 && cmp_act[0] != '0) |-> pwm_o);
endmodule

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  localparam int SYNC = 3;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       mode_pwm = 0;
  logic [2:0] psc_sel = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] flag_clr = 0;
  logic [2:0] flags;
  logic [7:0] cnt;
  logic       pwm;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmp_timer u_cmp_timer (
    .clk_i(clk), .rst_ni(rst_n), .mode_pwm_i(mode_pwm), .psc_sel_i(psc_sel),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .flag_clr_i(flag_clr), .flags_o(flags), .cnt_o(cnt), .pwm_o(pwm)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_top, m_blk, m_psc, m_flags;
  int m_stage[2], m_act[2];
  bit q_a[$], q_b[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_top = 255; m_blk = 0; m_psc = 0; m_flags = 0;
      m_stage = '{0, 0}; m_act = '{0, 0};
      q_a.delete(); q_b.delete();
      for (int i = 0; i < SYNC; i++) begin q_a.push_back(0); q_b.push_back(0); end
    end else begin
      int div, wc, wt, ovf, s_a, s_b;
      bit tick, wrap, roll;
      bit mt[2];
      int wcmp[2];
      case (psc_sel)
        1: div = 1; 2: div = 8; 3: div = 64; 4: div = 256; 5: div = 1024;
        default: div = 0;
      endcase
      tick = (div != 0) && ((m_psc % div) == div - 1);
      wc = wr_en && wr_addr == 0;
      wt = wr_en && wr_addr == 3;
      wcmp[0] = wr_en && wr_addr == 1;
      wcmp[1] = wr_en && wr_addr == 2;
      for (int c = 0; c < 2; c++) mt[c] = tick && !m_blk && m_cnt == m_act[c];
      wrap = tick && !wc && m_cnt == m_top;
      roll = tick && !wc && m_cnt == 255;
      ovf = mode_pwm ? wrap : roll;
      s_a = q_a.pop_front(); q_a.push_back(mt[0]);
      s_b = q_b.pop_front(); q_b.push_back(mt[1]);
      m_flags = (m_flags & ~int'(flag_clr)) | (s_b << 2) | (s_a << 1) | ovf;
      for (int c = 0; c < 2; c++) begin
        if (wcmp[c] && !mode_pwm) m_act[c] = wr_data;
        else if (mode_pwm && wrap) m_act[c] = m_stage[c];
        if (wcmp[c]) m_stage[c] = wr_data;
      end
      if (wc) begin m_cnt = wr_data; m_blk = 1; end
      else if (tick) begin m_blk = 0; m_cnt = (m_cnt == m_top) ? 0 : (m_cnt + 1) % 256; end
      if (wt) m_top = wr_data;
      m_psc = (m_psc + 1) % 1024;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cnt == m_cnt, "R1 model count", cnt, m_cnt);
      chk(flags == m_flags, "R3 model flags", flags, m_flags);
      chk(pwm == (mode_pwm && m_cnt < m_act[0]), "R11 model pwm", pwm,
          (mode_pwm && m_cnt < m_act[0]));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = 2'(a); wr_data = 8'(d);
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic clr(input int b);
    @(negedge clk); #1; flag_clr = 3'(b);
    @(negedge clk); #1; flag_clr = 0;
  endtask

  task automatic sel(input int s);
    @(negedge clk); #1; psc_sel = 3'(s);
  endtask

  task automatic poll(input int v);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (cnt == 8'(v)) break;
    end
    #1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    done = 1;
    summary();
  end

  initial begin
    int prev, mx, c0, hi;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R12 reset state
    chk(cnt == 0, "R12 reset count", cnt, 0);
    chk(flags == 0, "R12 reset flags", flags, 0);
    chk(pwm == 0, "R12 reset pwm", pwm, 0);

    // R1 / R2 clear-on-compare sequence, channels at 1
    wr(3, 2); wr(1, 1); wr(2, 1); wr(0, 0);
    clr(7);
    sel(1);
    cyc(1);
    prev = cnt; mx = prev;
    for (int i = 0; i < 9; i++) begin
      cyc(1);
      chk(cnt == ((prev == 2) ? 0 : prev + 1), "R1 count step", cnt,
          (prev == 2) ? 0 : prev + 1);
      prev = cnt;
      if (cnt > mx) mx = cnt;
    end
    chk(mx == 2, "R2 channels never clear count", mx, 2);
    chk(flags[2] == 1, "R2 channel B own flag", flags[2], 1);
    chk(flags[0] == 0, "R5 no overflow at period clear", flags[0], 0);

    // R4 compare A equal to period
    wr(1, 2);
    clr(2); cyc(6);
    chk(flags[1] == 1, "R4 match at period flagged", flags[1], 1);
    clr(2); cyc(6);
    chk(flags[1] == 1, "R4 match at period again", flags[1], 1);

    // R10 set wins over held clear: one visible cycle per period of 3
    @(negedge clk); #1; flag_clr = 3'b010;
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (flags[1]) hi++;
    end
    #1; flag_clr = 0;
    chk(hi == 4, "R10 set wins over clear", hi, 4);
    sel(0); cyc(6);
    clr(7); cyc(1);
    chk(flags == 0, "R10 clear by writing 1", flags, 0);

    // R5 true rollover in clear-on-compare mode
    wr(3, 100); wr(0, 250); sel(1);
    cyc(3);
    chk(flags[0] == 0, "R5 before rollover", flags[0], 0);
    cyc(8);
    chk(flags[0] == 1, "R5 rollover sets overflow", flags[0], 1);

    // R8 counter write blocks next match
    sel(0); wr(3, 20); wr(1, 5); wr(0, 5);
    cyc(5); clr(7);
    sel(1); cyc(6);
    chk(flags[1] == 0, "R8 write blocks match", flags[1], 0);
    cyc(25);
    chk(flags[1] == 1, "R8 later match not blocked", flags[1], 1);

    // R7 clear-on-compare write takes effect at once
    sel(0); wr(3, 30); wr(0, 7); cyc(5); clr(7);
    wr(1, 10); sel(1); cyc(10);
    chk(flags[1] == 1, "R7 immediate compare in ctc", flags[1], 1);

    // R9 prescaler rates
    sel(0); wr(3, 255); wr(0, 0);
    sel(2); c0 = cnt; cyc(64);
    chk(cnt - c0 == 8, "R9 divide by 8", cnt - c0, 8);
    sel(3); c0 = cnt; cyc(128);
    chk(cnt - c0 == 2, "R9 divide by 64", cnt - c0, 2);
    sel(0); c0 = cnt; cyc(20);
    chk(cnt == c0, "R9 stop", cnt, c0);

    // R6 PWM overflow at period wrap
    @(negedge clk); #1; mode_pwm = 1;
    wr(3, 5); wr(0, 0); clr(7); sel(1);
    cyc(3);
    chk(flags[0] == 0, "R6 no overflow mid period", flags[0], 0);
    cyc(6);
    chk(flags[0] == 1, "R6 overflow at wrap", flags[0], 1);

    // R7 staged compare in PWM mode
    wr(3, 9); wr(1, 3); cyc(12);
    poll(1); wr(1, 7);
    poll(5);
    chk(pwm == 0, "R7 old compare still active", pwm, 0);
    poll(0); poll(5);
    chk(pwm == 1, "R7 staged compare loaded at wrap", pwm, 1);

    // R11 waveform width
    wr(1, 0); cyc(12); poll(0);
    hi = 0;
    for (int i = 0; i < 10; i++) begin if (pwm) hi++; cyc(1); end
    chk(hi == 0, "R11 zero compare keeps low", hi, 0);
    wr(1, 3); cyc(12); poll(0);
    hi = 0;
    for (int i = 0; i < 10; i++) begin if (pwm) hi++; cyc(1); end
    chk(hi == 3, "R11 high width", hi, 3);
    @(negedge clk); #1; mode_pwm = 0; cyc(1);
    chk(pwm == 0, "R11 low in ctc mode", pwm, 0);

    cyc(4);
    done = 1;
    summary();
  end
endmodule